// File: doc/BRIEF.md
# Hinted History Branch Direction Predictor

This block predicts the direction of conditional branches at the fetch stage. It keeps a small, fully associative table keyed by the branch address. Each entry records the last sixteen resolved outcomes of its branch in a circular log. When the fetch stage asks about a branch, the block looks for the address in the table. On a match, it replays the outcome the same branch produced sixteen encounters earlier. When there is no match, it falls back to a static rule. That rule uses a compiler-set hint bit, which marks a branch as closing a loop or guarding an if, together with a flag that says whether the branch jumps backwards.

When a branch resolves, the execute side reports its address, its real direction and its static attributes. If the branch is already in the table, the real direction is written into its log and the log pointer moves forward. Otherwise the branch receives a new entry. New entries go first to empty slots, and after that to the slot allocated longest ago. Because the replay distance is sixteen, any branch whose behaviour repeats with a period dividing sixteen is predicted perfectly once its log has been learned. A loop that always runs four iterations is one such case.

Top module: `branch_hint_predictor`

## Requirements
- R1: After a synchronous reset, `pred_valid`, `pred_hit` and `pred_taken` are 0, and the table is empty, so every lookup misses until a resolution allocates an entry.
- R2: A lookup presented with `lk_valid` = 1 produces `pred_valid` = 1 one clock later. In a cycle that follows no lookup, all three prediction outputs are 0.
- R3: A lookup that misses, with `lk_hint_loop` = 1 (loop branch), is predicted taken (`pred_taken` = 1, `pred_hit` = 0).
- R4: A lookup that misses, with `lk_hint_loop` = 0 (if branch) and `lk_backward` = 0, is predicted not taken, so the fall-through path is fetched.
- R5: A lookup that misses, with `lk_backward` = 1, is predicted taken whatever the hint bit says.
- R6: A resolution (`rs_valid` = 1) for an address not in the table allocates an entry for it.
  - Log position 0 of the new entry holds the actual outcome `rs_taken`.
  - The other fifteen positions hold the static rule applied to `rs_hint_loop`/`rs_backward`.
  - The entry's pointer is set to 1.
  - A lookup of that address in any later cycle hits.
- R7: On a hit, the prediction is the log bit at the entry's pointer. Each resolution of a present address overwrites that bit with the outcome and advances the pointer by one, wrapping from 15 to 0. The prediction therefore equals the outcome recorded sixteen resolutions earlier.
- R8: A branch with a repeating taken, taken, taken, not-taken pattern has zero mispredictions once sixteen resolutions have been recorded.
- R9: The table holds 8 entries. Once all 8 are in use, allocating a new address replaces the entry that was allocated earliest, regardless of how recently that entry was used.
- R10: When a lookup and a resolution of the same address occur in the same cycle, the prediction uses the log bit as it was before that resolution.
- R11: Lookups alone do not change the table: repeated lookups of an address with no resolution in between give the same hit and direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | PC_W | Address of the branch being fetched |
| lk_hint_loop | input | 1 | Compiler hint: 1 loop branch, 0 if branch |
| lk_backward | input | 1 | 1 when the branch target lies below the branch address |
| rs_valid | input | 1 | A branch resolved this cycle |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual direction of the resolved branch |
| rs_hint_loop | input | 1 | Hint bit of the resolved branch, used to fill a new entry |
| rs_backward | input | 1 | Backward flag of the resolved branch, used to fill a new entry |
| pred_valid | output | 1 | Registered: a prediction is presented |
| pred_hit | output | 1 | Registered: the looked-up address was in the table |
| pred_taken | output | 1 | Registered: predicted direction, 1 taken |

## Verification
A prediction is due exactly one clock after its lookup is sampled. A resolution changes the table on its own edge, so a lookup in the next cycle sees the new state and a lookup in the same cycle sees the old one. The bench drives inputs on the falling edge. It computes the expected prediction from its reference table before applying that cycle's resolution, and compares all three outputs at the following falling edge, one full cycle later. Directed sequences pin down:
- pointer wrap;
- the period-four loop;
- the same-cycle ordering;
- oldest-first eviction.

Seeded random traffic over a pool larger than the table exercises the rest.

// File: rtl/bhp_pkg.sv
package bhp_pkg;

  // Encoding of the compiler hint bit carried with each branch.
  typedef enum logic {
    HINT_IF   = 1'b0,
    HINT_LOOP = 1'b1
  } hint_e;

  // Direction used when no history exists for a branch.
  function automatic logic static_dir(input logic hint_loop, input logic backward);
    return (hint_e'(hint_loop) == HINT_LOOP) || backward;
  endfunction

endpackage

// File: rtl/bhp_match.sv
// Parallel tag compare over every valid entry; returns hit and binary index.
module bhp_match #(
  parameter int N     = 8,
  parameter int PC_W  = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]      vld,
  input  logic [N*PC_W-1:0] tags,
  input  logic [PC_W-1:0]   pc,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vld[i] && (tags[i*PC_W +: PC_W] == pc)) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/bhp_victim.sv
// Allocation pointer: walks entries in order, so the next victim is
// always the entry allocated longest ago (empty slots come first).
module bhp_victim #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (adv) begin
      idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
  end

endmodule

// File: rtl/bhp_entry_array.sv
// Storage for tags, valid bits, circular direction logs and log pointers.
module bhp_entry_array #(
  parameter int N       = 8,
  parameter int PC_W    = 32,
  parameter int LOG_LEN = 16,
  parameter int IDX_W   = $clog2(N),
  parameter int PTR_W   = $clog2(LOG_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PC_W-1:0]   wr_pc,
  input  logic              fill_dir,
  input  logic              outcome,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [N-1:0]      vld,
  output logic [N*PC_W-1:0] tags,
  output logic              rd_bit
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(LOG_LEN - 1);
  localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

  logic [N-1:0] cur_bit;

  for (genvar e = 0; e < N; e++) begin : g_entry
    logic [LOG_LEN-1:0] log_q;
    logic [PTR_W-1:0]   ptr_q;
    logic [PC_W-1:0]    tag_q;
    logic               vld_q;
    logic               sel;

    assign sel = (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
        tag_q <= '0;
        log_q <= '0;
        ptr_q <= '0;
      end else if (alloc_en && sel) begin
        vld_q <= 1'b1;
        tag_q <= wr_pc;
        log_q <= {{(LOG_LEN-1){fill_dir}}, outcome};
        ptr_q <= PTR_ONE;
      end else if (upd_en && sel) begin
        log_q[ptr_q] <= outcome;
        ptr_q        <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
      end
    end

    assign cur_bit[e]              = log_q[ptr_q];
    assign vld[e]                  = vld_q;
    assign tags[e*PC_W +: PC_W]    = tag_q;
  end

  assign rd_bit = cur_bit[rd_idx];

endmodule

// File: rtl/branch_hint_predictor.sv
module branch_hint_predictor #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 8,
  parameter int LOG_LEN = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            lk_hint_loop,
  input  logic            lk_backward,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic            rs_hint_loop,
  input  logic            rs_backward,
  output logic            pred_valid,
  output logic            pred_hit,
  output logic            pred_taken
);
  import bhp_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int PTR_W = $clog2(LOG_LEN);

  logic [ENTRIES-1:0]      vld;
  logic [ENTRIES*PC_W-1:0] tags;
  logic                    lk_hit, rs_hit;
  logic [IDX_W-1:0]        lk_idx, rs_idx, vic_idx, wr_idx;
  logic                    hist_bit;
  logic                    alloc_en, upd_en;

  bhp_match #(.N(ENTRIES), .PC_W(PC_W), .IDX_W(IDX_W)) u_lk_match (
    .vld(vld), .tags(tags), .pc(lk_pc), .hit(lk_hit), .idx(lk_idx)
  );

  bhp_match #(.N(ENTRIES), .PC_W(PC_W), .IDX_W(IDX_W)) u_rs_match (
    .vld(vld), .tags(tags), .pc(rs_pc), .hit(rs_hit), .idx(rs_idx)
  );

  assign alloc_en = rs_valid && !rs_hit;
  assign upd_en   = rs_valid &&  rs_hit;
  assign wr_idx   = rs_hit ? rs_idx : vic_idx;

  bhp_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .adv(alloc_en), .idx(vic_idx)
  );

  bhp_entry_array #(
    .N(ENTRIES), .PC_W(PC_W), .LOG_LEN(LOG_LEN), .IDX_W(IDX_W), .PTR_W(PTR_W)
  ) u_array (
    .clk(clk), .rst(rst),
    .alloc_en(alloc_en), .upd_en(upd_en), .wr_idx(wr_idx), .wr_pc(rs_pc),
    .fill_dir(static_dir(rs_hint_loop, rs_backward)), .outcome(rs_taken),
    .rd_idx(lk_idx), .vld(vld), .tags(tags), .rd_bit(hist_bit)
  );

  // Registered prediction: state read here is the pre-update state, so a
  // same-cycle resolution is seen only by later lookups.
  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_hit   <= 1'b0;
      pred_taken <= 1'b0;
    end else begin
      pred_valid <= lk_valid;
      pred_hit   <= lk_valid && lk_hit;
      pred_taken <= lk_valid && (lk_hit ? hist_bit : static_dir(lk_hint_loop, lk_backward));
    end
  end

endmodule

// File: rtl/bhp_checker.sv
module bhp_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_valid,
  input logic [PC_W-1:0] lk_pc,
  input logic            lk_hint_loop,
  input logic            lk_backward,
  input logic            rs_valid,
  input logic [PC_W-1:0] rs_pc,
  input logic            pred_valid,
  input logic            pred_hit,
  input logic            pred_taken
);

  AST_PRED_FOLLOWS_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_valid); // R2

  AST_IDLE_OUTPUTS_LOW: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!pred_valid && !pred_hit && !pred_taken)); // R2

  AST_LOOP_MISS_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_hint_loop) |=> (pred_hit || pred_taken)); // R3

  AST_IF_MISS_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_hint_loop && !lk_backward) |=> (pred_hit || !pred_taken)); // R4

  AST_BACKWARD_MISS_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_backward) |=> (pred_hit || pred_taken)); // R5

  AST_RESOLVED_PC_HITS: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && $past(rs_valid) && (lk_pc == $past(rs_pc))) |=> pred_hit); // R6

endmodule

bind branch_hint_predictor bhp_checker #(.PC_W(PC_W)) i_bhp_checker (
  .clk(clk), .rst(rst),
  .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_hint_loop(lk_hint_loop), .lk_backward(lk_backward),
  .rs_valid(rs_valid), .rs_pc(rs_pc),
  .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_taken(pred_taken)
);

// File: tb/test_branch_hint_predictor.sv
module test_branch_hint_predictor;
  localparam int PCW = 32;
  localparam int NE  = 8;
  localparam int LL  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 0, lk_hint_loop = 0, lk_backward = 0;
  logic rs_valid = 0, rs_taken = 0, rs_hint_loop = 0, rs_backward = 0;
  logic [PCW-1:0] lk_pc = '0, rs_pc = '0;
  logic pred_valid, pred_hit, pred_taken;

  always #5 clk = ~clk;

  branch_hint_predictor #(.PC_W(PCW), .ENTRIES(NE), .LOG_LEN(LL)) i_branch_hint_predictor (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_hint_loop(lk_hint_loop), .lk_backward(lk_backward),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
    .rs_hint_loop(rs_hint_loop), .rs_backward(rs_backward),
    .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_taken(pred_taken)
  );

  int  n_vec = 0;
  int  n_bad = 0;
  bit  finished = 0;
  logic got_h, got_t;

  // Reference table
  logic [PCW-1:0] m_tag [NE];
  logic           m_vld [NE];
  logic [LL-1:0]  m_log [NE];
  int             m_ptr [NE];
  int             m_vic;

  function automatic logic ref_static(input logic h, input logic b);
    return h | b;
  endfunction

  function automatic int m_find(input logic [PCW-1:0] pc);
    for (int i = 0; i < NE; i++) if (m_vld[i] && m_tag[i] == pc) return i;
    return -1;
  endfunction

  task automatic m_clear();
    for (int i = 0; i < NE; i++) begin
      m_vld[i] = 0; m_tag[i] = '0; m_log[i] = '0; m_ptr[i] = 0;
    end
    m_vic = 0;
  endtask

  task automatic m_resolve(input logic [PCW-1:0] pc, input logic t, input logic h, input logic b);
    int i;
    i = m_find(pc);
    if (i >= 0) begin
      m_log[i][m_ptr[i]] = t;
      m_ptr[i] = (m_ptr[i] + 1) % LL;
    end else begin
      i = m_vic;
      m_vld[i] = 1; m_tag[i] = pc;
      m_log[i] = {LL{ref_static(h, b)}};
      m_log[i][0] = t;
      m_ptr[i] = 1;
      m_vic = (m_vic + 1) % NE;
    end
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Called at a falling edge. Drives one cycle, checks the outputs one cycle later.
  task automatic step(input logic lv, input logic [PCW-1:0] lpc, input logic lh, input logic lb,
                      input logic rv, input logic [PCW-1:0] rpc, input logic rt,
                      input logic rh, input logic rb, input string req);
    int   i;
    logic eh, et;
    lk_valid = lv; lk_pc = lpc; lk_hint_loop = lh; lk_backward = lb;
    rs_valid = rv; rs_pc = rpc; rs_taken = rt; rs_hint_loop = rh; rs_backward = rb;
    i  = m_find(lpc);
    eh = lv && (i >= 0);
    et = lv && ((i >= 0) ? m_log[i][m_ptr[i]] : ref_static(lh, lb));
    if (rv) m_resolve(rpc, rt, rh, rb);
    @(posedge clk);
    @(negedge clk);
    lk_valid = 0; rs_valid = 0;
    got_h = pred_hit; got_t = pred_taken;
    check(req, "pred_valid", int'(pred_valid), int'(lv));
    check(req, "pred_hit",   int'(pred_hit),   int'(eh));
    check(req, "pred_taken", int'(pred_taken), int'(et));
  endtask

  task automatic look(input logic [PCW-1:0] pc, input logic h, input logic b, input string req);
    step(1, pc, h, b, 0, '0, 0, 0, 0, req);
  endtask

  task automatic resolve(input logic [PCW-1:0] pc, input logic t, input logic h, input logic b, input string req);
    step(0, '0, 0, 0, 1, pc, t, h, b, req);
  endtask

  task automatic do_reset();
    rst = 1;
    lk_valid = 0; rs_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_clear();
  endtask

  localparam logic [PCW-1:0] PC_A = 32'h0000_0100;
  localparam logic [PCW-1:0] PC_B = 32'h0000_0200;
  localparam logic [PCW-1:0] PC_D = 32'h0000_0900;

  initial begin
    int miss;
    int r;
    @(negedge clk);
    do_reset();

    // R1: outputs low after reset, table empty
    check("R1", "pred_valid", int'(pred_valid), 0);
    check("R1", "pred_hit",   int'(pred_hit),   0);
    check("R1", "pred_taken", int'(pred_taken), 0);
    look(PC_A, 0, 0, "R1");
    check("R1", "empty table hit", int'(got_h), 0);

    // R2: idle cycle outputs
    step(0, '0, 0, 0, 0, '0, 0, 0, 0, "R2");

    // R3, R4, R5: static fallback
    look(32'h10, 1, 0, "R3");  check("R3", "loop miss taken",     int'(got_t), 1);
    look(32'h14, 0, 0, "R4");  check("R4", "if miss not taken",   int'(got_t), 0);
    look(32'h18, 0, 1, "R5");  check("R5", "backward miss taken", int'(got_t), 1);
    look(32'h1c, 1, 1, "R5");

    // R6: allocate if-branch with outcome taken; pointer 1 reads fill bit 0
    resolve(PC_A, 1, 0, 0, "R6");
    look(PC_A, 0, 0, "R6");
    check("R6", "alloc hit", int'(got_h), 1);
    check("R6", "fill bit at ptr 1", int'(got_t), 0);

    // R11: lookups alone leave state unchanged
    look(PC_A, 0, 0, "R11");
    check("R11", "repeat hit", int'(got_h), 1);
    check("R11", "repeat dir", int'(got_t), 0);

    // R7: 15 not-taken resolutions wrap the pointer back to bit 0 (taken)
    for (int k = 0; k < 15; k++) resolve(PC_A, 0, 0, 0, "R7");
    look(PC_A, 0, 0, "R7");
    check("R7", "wrap replays bit 0", int'(got_t), 1);

    // R10: same-cycle lookup and resolve sees pre-update bit
    step(1, PC_A, 0, 0, 1, PC_A, 0, 0, 0, "R10");
    check("R10", "pre-update bit", int'(got_t), 1);
    look(PC_A, 0, 0, "R10");
    check("R10", "next ptr bit", int'(got_t), 0);

    // R8: loop of four iterations (T,T,T,N)
    for (int k = 0; k < 16; k++) resolve(PC_B, (k % 4) != 3, 1, 1, "R8");
    miss = 0;
    for (int k = 0; k < 32; k++) begin
      step(1, PC_B, 1, 1, 1, PC_B, (k % 4) != 3, 1, 1, "R8");
      if (got_t != ((k % 4) != 3)) miss++;
    end
    check("R8", "learned loop mispredicts", miss, 0);

    // R9: fill the remaining six slots, then one more evicts the oldest (PC_A)
    for (int k = 0; k < 6; k++) resolve(32'h0000_0400 + 32'(k * 4), 1, 1, 0, "R9");
    look(PC_A, 0, 0, "R9");
    check("R9", "oldest still present when full", int'(got_h), 1);
    resolve(PC_D, 0, 0, 0, "R9");
    look(PC_A, 0, 0, "R9");
    check("R9", "oldest evicted", int'(got_h), 0);
    look(PC_B, 1, 1, "R9");
    check("R9", "second oldest kept", int'(got_h), 1);
    look(PC_D, 0, 0, "R9");
    check("R9", "new entry present", int'(got_h), 1);

    // R1: reset empties the table
    do_reset();
    look(PC_B, 0, 0, "R1");
    check("R1", "miss after reset", int'(got_h), 0);

    // Seeded random traffic over twelve addresses
    r = $urandom(32'd97531);
    for (int n = 0; n < 3000; n++) begin
      int li, ri;
      logic lv, rv;
      li = int'($urandom_range(11));
      ri = int'($urandom_range(11));
      lv = ($urandom_range(3) != 0);
      rv = ($urandom_range(2) != 0);
      step(lv, 32'h1000 + 32'(li * 4), li[0], li[1] & li[2],
           rv, 32'h1000 + 32'(ri * 4), $urandom_range(1) != 0, ri[0], ri[1] & ri[2],
           "R7");
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL R2 watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule